// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block steers branch divergence for a 32-lane SIMD processor that runs a single thread of SIMD instructions. Every lane executes every instruction, and the active-lane mask held here decides which lanes commit their results. When a conditional branch splits the lanes, the sequencer sends a push command with the per-lane predicate vector. The block saves the current mask on a hardware stack and narrows the live mask to the lanes whose predicate is set.

At the else-marker, a complement command hands control to the lanes of the saved parent that were not on the first path. At reconvergence, a pop restores the mask that was live before the branch. Two status outputs tell the sequencer that the current path holds no lanes, or holds every lane of its parent. The sequencer can use them to jump over a path that nobody needs.

Stack depth is a parameter. A push into a full stack, or a pop or complement with an empty stack, is refused and flagged for one cycle.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the depth is 0, and the overflow, underflow, path-empty and path-full outputs are all low.
- R2: A push (cmd_valid high, cmd = 2'b01) with depth below DEPTH saves the current mask on the stack, sets the mask to the old mask AND pred, and raises depth by one. The new values are visible after the next rising edge.
- R3: A complement (cmd = 2'b10) with depth above 0 sets the mask to the saved parent mask AND NOT the current mask, and leaves the depth unchanged.
- R4: A pop (cmd = 2'b11) with depth above 0 restores the most recently saved mask and lowers depth by one. Nested branches unwind in last-in, first-out order.
- R5: A push when depth equals DEPTH leaves the mask and depth unchanged. It raises overflow for exactly the cycle after the command.
- R6: A pop or a complement when depth is 0 leaves the mask and depth unchanged. It raises underflow for exactly the cycle after the command.
- R7: path_empty is high exactly while depth is above 0 and the active mask is all zeros.
- R8: path_full is high exactly while depth is above 0 and the active mask equals the saved parent mask.
- R9: Nothing changes while cmd_valid is low, whatever cmd holds. cmd = 2'b00 with cmd_valid high also changes nothing. In both cases overflow and underflow are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | 00 none, 01 push, 10 complement, 11 pop |
| pred | input | LANES (32) | Per-lane branch predicate, used by push |
| active_mask | output | LANES (32) | Lanes that commit results |
| depth | output | $clog2(DEPTH+1) (4) | Number of saved masks |
| overflow | output | 1 | Push refused on a full stack (one-cycle pulse) |
| underflow | output | 1 | Pop or complement refused on an empty stack (one-cycle pulse) |
| path_empty | output | 1 | Current path has no active lane |
| path_full | output | 1 | Current path holds every lane of its parent |

## Verification
The bench fills the stack to its limit and pushes once more. A design with an off-by-one full test would either corrupt the top entry or drop a level that a later pop needs. It issues complement and pop on an empty stack, where a faulty design would invert against all ones or wrap the depth counter. Three-deep nesting with distinct predicates exposes any stack that restores the wrong entry. Uniform predicates, all ones and all zeros, followed by a complement check that the two path outputs track the mask and the parent, and not the predicate.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    MC_NONE = 2'b00,
    MC_PUSH = 2'b01,
    MC_FLIP = 2'b10,
    MC_POP  = 2'b11
  } mask_cmd_e;
endpackage

// File: rtl/mask_lifo.sv
module mask_lifo #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic [LANES-1:0] wr_mask,
  output logic [LANES-1:0] top_mask,
  output logic [DW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [LANES-1:0] slot [DEPTH];
  logic [DW-1:0]    top_idx;

  // one register per entry, written only when it is the next free slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [LANES-1:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent <= '0;
      else if (push_en && level == DW'(i)) ent <= wr_mask;
    end
    assign slot[i] = ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       level <= '0;
    else if (push_en) level <= level + 1'b1;
    else if (pop_en)  level <= level - 1'b1;
  end

  assign full     = (level == DW'(DEPTH));
  assign empty    = (level == '0);
  assign top_idx  = level - 1'b1;
  assign top_mask = empty ? '1 : slot[top_idx[AW-1:0]];

  // stack pointer never passes its bound
  always_comb begin
    if (rst_n) a_r5_level_bound: assert (level <= DW'(DEPTH));
  end
endmodule

// File: rtl/mask_next.sv
module mask_next
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] parent,
  input  logic             full,
  input  logic             empty,
  output logic [LANES-1:0] nxt_mask,
  output logic             do_push,
  output logic             do_pop,
  output logic             ovf_ev,
  output logic             udf_ev
);
  function automatic logic [LANES-1:0] f_narrow(input logic [LANES-1:0] m,
                                                input logic [LANES-1:0] p);
    return m & p;
  endfunction

  function automatic logic [LANES-1:0] f_other(input logic [LANES-1:0] par,
                                               input logic [LANES-1:0] m);
    return par & ~m;
  endfunction

  mask_cmd_e op;
  assign op = mask_cmd_e'(cmd);

  always_comb begin
    nxt_mask = cur_mask;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    ovf_ev   = 1'b0;
    udf_ev   = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        MC_PUSH: if (full) ovf_ev = 1'b1;
                 else begin do_push = 1'b1; nxt_mask = f_narrow(cur_mask, pred); end
        MC_FLIP: if (empty) udf_ev = 1'b1;
                 else nxt_mask = f_other(parent, cur_mask);
        MC_POP:  if (empty) udf_ev = 1'b1;
                 else begin do_pop = 1'b1; nxt_mask = parent; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic [DW-1:0]    depth,
  output logic             overflow,
  output logic             underflow,
  output logic             path_empty,
  output logic             path_full
);
  logic [LANES-1:0] mask_q, nxt_mask, parent;
  logic do_push, do_pop, ovf_ev, udf_ev, full, empty;

  mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push_en(do_push), .pop_en(do_pop),
    .wr_mask(mask_q), .top_mask(parent), .level(depth),
    .full(full), .empty(empty)
  );

  mask_next #(.LANES(LANES)) u_next (
    .cmd_valid(cmd_valid), .cmd(cmd), .pred(pred), .cur_mask(mask_q),
    .parent(parent), .full(full), .empty(empty), .nxt_mask(nxt_mask),
    .do_push(do_push), .do_pop(do_pop), .ovf_ev(ovf_ev), .udf_ev(udf_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      mask_q    <= nxt_mask;
      overflow  <= ovf_ev;
      underflow <= udf_ev;
    end
  end

  assign active_mask = mask_q;
  assign path_empty  = !empty && (mask_q == '0);
  assign path_full   = !empty && (mask_q == parent);

  // R2: a push only narrows the mask and deepens the stack by one
  a_r2_push_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b01 && !full) |=>
      ((active_mask & ~$past(active_mask)) == '0) && depth == $past(depth) + 1'b1);
  // R3: the complement path never overlaps the path it replaces
  a_r3_flip_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b10 && !empty) |=>
      ((active_mask & $past(active_mask)) == '0) && $stable(depth));
  // R4: a pop returns one level
  a_r4_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b11 && !empty) |=> depth == $past(depth) - 1'b1);
  // R5: a refused push keeps the mask and flags overflow
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b01 && full) |=> overflow && $stable(active_mask) && $stable(depth));
  // R6: a refused pop or complement keeps the mask and flags underflow
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd[1] && empty) |=> underflow && $stable(active_mask) && $stable(depth));
  // R9: no strobe, no change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(active_mask) && $stable(depth) && !overflow && !underflow);
endmodule

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] active_mask;
  logic [3:0] depth;
  logic overflow, underflow, path_empty, path_full;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side reference state
  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk [DEPTH];
  int m_dep;
  bit e_ovf, e_udf;

  always #4 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .pred(pred),
    .active_mask(active_mask), .depth(depth), .overflow(overflow),
    .underflow(underflow), .path_empty(path_empty), .path_full(path_full)
  );

  task automatic check(input string req);
    logic [LANES-1:0] par;
    bit e_none, e_all;
    par    = (m_dep > 0) ? m_stk[m_dep-1] : '1;
    e_none = (m_dep > 0) && (m_mask == '0);
    e_all  = (m_dep > 0) && (m_mask == par);
    n_vec++;
    if (active_mask !== m_mask || depth !== 4'(m_dep) || overflow !== e_ovf ||
        underflow !== e_udf || path_empty !== e_none || path_full !== e_all) begin
      n_bad++;
      $display("FAIL %s: mask=%h depth=%0d ovf=%b udf=%b pe=%b pf=%b expected mask=%h depth=%0d ovf=%b udf=%b pe=%b pf=%b",
               req, active_mask, depth, overflow, underflow, path_empty, path_full,
               m_mask, m_dep, e_ovf, e_udf, e_none, e_all);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] c, input logic [LANES-1:0] p,
                      input string req);
    @(negedge clk);
    cmd_valid = v; cmd = c; pred = p;
    e_ovf = 0; e_udf = 0;
    if (v) begin
      if (c == 2'b01) begin
        if (m_dep == DEPTH) e_ovf = 1;
        else begin m_stk[m_dep] = m_mask; m_dep++; m_mask = m_mask & p; end
      end else if (c == 2'b10) begin
        if (m_dep == 0) e_udf = 1;
        else m_mask = m_stk[m_dep-1] & ~m_mask;
      end else if (c == 2'b11) begin
        if (m_dep == 0) e_udf = 1;
        else begin m_dep--; m_mask = m_stk[m_dep]; end
      end
    end
    @(posedge clk);
    #2;
    check(req);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    m_mask = '1; m_dep = 0; e_ovf = 0; e_udf = 0;
    repeat (3) @(posedge clk);
    #2 check("R1");
    @(negedge clk) rst_n = 1;
    @(posedge clk); #2 check("R1");
  endtask

  task automatic t_branch();
    step(1, 2'b01, 32'h0000_FFFF, "R2");
    step(1, 2'b10, 32'h0,         "R3");
    step(1, 2'b11, 32'h0,         "R4");
  endtask

  task automatic t_nest();
    step(1, 2'b01, 32'hF0F0_F0F0, "R2");
    step(1, 2'b01, 32'hFF00_FF00, "R2");
    step(1, 2'b01, 32'h1234_5678, "R2");
    step(1, 2'b10, 32'h0,         "R3");
    step(1, 2'b11, 32'h0,         "R4");
    step(1, 2'b10, 32'h0,         "R3");
    step(1, 2'b11, 32'h0,         "R4");
    step(1, 2'b11, 32'h0,         "R4");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) step(1, 2'b01, ~(32'h1 << i), "R2");
    step(1, 2'b01, 32'h0, "R5");
    step(1, 2'b00, 32'h0, "R5");
    for (int i = 0; i < DEPTH; i++) step(1, 2'b11, 32'h0, "R4");
  endtask

  task automatic t_underflow();
    step(1, 2'b11, 32'h0, "R6");
    step(1, 2'b10, 32'h0, "R6");
    step(1, 2'b00, 32'h0, "R6");
  endtask

  task automatic t_idle();
    step(1, 2'b01, 32'hAAAA_5555, "R2");
    step(0, 2'b01, 32'h0,         "R9");
    step(0, 2'b11, 32'h0,         "R9");
    step(1, 2'b00, 32'h0,         "R9");
    step(1, 2'b11, 32'h0,         "R4");
  endtask

  task automatic t_uniform();
    step(1, 2'b01, 32'hFFFF_FFFF, "R8");
    step(1, 2'b10, 32'h0,         "R7");
    step(1, 2'b11, 32'h0,         "R4");
    step(1, 2'b01, 32'h0,         "R7");
    step(1, 2'b10, 32'h0,         "R8");
    step(1, 2'b01, 32'h0F0F_0F0F, "R8");
    step(1, 2'b01, 32'h0,         "R7");
    step(1, 2'b11, 32'h0,         "R4");
    step(1, 2'b11, 32'h0,         "R4");
  endtask

  initial begin
    t_reset();
    t_branch();
    t_nest();
    t_overflow();
    t_underflow();
    t_idle();
    t_uniform();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule